// File: doc/BRIEF.md
# Selectable-Tap Watchdog Timer

This block is the counting core of a microcontroller watchdog. It counts enable ticks from one of two sources, which a configuration input chooses. One source is a free-running low-speed oscillator, presented here as a one-cycle tick input. The other is a quarter-rate pulse derived from the system clock. The count runs through a prescaler and then a main counter whose carry acts as an extra top bit. A tap field picks one bit of that extended counter. When the picked bit first turns on, the block emits a single time-out pulse and the whole chain starts again from zero.

Software keeps the watchdog quiet by pulsing the clear strobe before the selected period runs out. A configuration-level enable switches the block off completely: while it is low, the chain stays at zero and neither the clear strobe nor any tick has an effect. A halt input marks the state in which the system clock is stopped. In that state the quarter-rate source produces no ticks, but the low-speed oscillator tick still counts. The reset or wake-up that would follow a time-out is handled outside this block. The block has no data stream, so every pin is a plain control or status line.

Top module: `wdt_tap_timer`

## Requirements
- R1: While reset is active and after it is released, `timeout_pulse` is 0, and the prescaler and the counter are at zero.
- R2: `cfg_src_sel` = 0 counts `slow_tick` pulses. `cfg_src_sel` = 1 counts the internal system-clock-divided-by-4 pulse.
- R3: The divided source is a free-running 2-bit divider. It gives a one-clock enable once every 4 clocks, so with `cfg_src_sel` = 1 a tap's period measured in clocks is exactly 4 times its period measured in ticks.
- R4: With `tap_sel` = k, the time-out occurs when bit k of the extended counter {carry, counter} first rises. That takes 2^k x 2^PRE_W count ticks, where tap CNT_W is the counter's carry. Each step of `tap_sel` therefore doubles the period.
- R5: `timeout_pulse` is high for exactly one clock. In the clock edge that raises it, the prescaler and the counter return to zero, so consecutive time-outs are evenly spaced.
- R6: A `clr_strobe` sampled high zeroes the prescaler and the counter at that clock edge. It also suppresses any time-out at that edge, and the next time-out follows a full period later.
- R7: While `cfg_enable` = 0, no time-out is produced, the chain is held at zero and `clr_strobe` has no effect. After enabling, the first time-out comes a full period later.
- R8: While `sys_halt` = 1, the divided source produces no ticks and a chain counting from it stays frozen. Ticks on `slow_tick` keep counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Configuration enable for the watchdog; 0 makes every operation a no-op |
| cfg_src_sel | input | 1 | Count source: 0 low-speed tick, 1 system clock divided by 4 |
| sys_halt | input | 1 | System clock considered stopped; gates the divided source |
| slow_tick | input | 1 | One-cycle tick from the low-speed oscillator |
| tap_sel | input | $clog2(CNT_W+1) | Index of the extended-counter bit that triggers the time-out |
| clr_strobe | input | 1 | Software clear of the count chain |
| timeout_pulse | output | 1 | One-clock time-out pulse |

## Verification
The bench builds the block with PRE_W = 2 and the default CNT_W = 7. With these values even the carry tap fires after 2048 clocks on the divided source, so the bench can measure the full doubling sequence, including the topmost tap, as exact pulse-to-pulse intervals. The `slow_tick` pulse comes every 5 clocks, which separates the two sources by their periods. Clear, disable and halt are each checked by counting pulses across windows longer than the active period. The first time-out after a clear or an enable must fall within the phase uncertainty of the divider.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    SRC_SLOW   = 1'b0,
    SRC_SYSDIV = 1'b1
  } wdt_src_e;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
  import wdt_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  wdt_src_e src,
  input  logic     halt,
  input  logic     slow_tick,
  output logic     count_tick
);
  logic [DIV_W-1:0] div_q;
  logic             sys_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // Divider keeps running; halt only masks its enable pulse.
  assign sys_tick   = (&div_q) & ~halt;
  assign count_tick = (src == SRC_SYSDIV) ? sys_tick : slow_tick;
endmodule

// File: rtl/wdt_count_chain.sv
module wdt_count_chain #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           restart,
  input  logic           step_in,
  output logic [CNT_W:0] ext_q,
  output logic [CNT_W:0] ext_nxt,
  output logic           ext_step
);
  logic [PRE_W-1:0] pre_q;

  assign ext_step = step_in & (&pre_q);
  assign ext_nxt  = ext_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ext_q <= '0;
    end else if (hold || restart) begin
      pre_q <= '0;
      ext_q <= '0;
    end else if (step_in) begin
      pre_q <= pre_q + 1'b1;
      if (ext_step) ext_q <= ext_nxt;
    end
  end
endmodule

// File: rtl/wdt_tap_mux.sv
module wdt_tap_mux #(
  parameter int TAPS  = 8,
  parameter int SEL_W = 3
) (
  input  logic [TAPS-1:0]  cur,
  input  logic [TAPS-1:0]  nxt,
  input  logic [SEL_W-1:0] sel,
  output logic             rise
);
  localparam int SLOTS = 2 ** SEL_W;
  logic [SLOTS-1:0] rise_pad;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < TAPS) begin : g_tap
      assign rise_pad[i] = nxt[i] & ~cur[i];
    end else begin : g_pad
      assign rise_pad[i] = 1'b0;
    end
  end

  assign rise = rise_pad[sel];
endmodule

// File: rtl/wdt_tap_timer.sv
module wdt_tap_timer
  import wdt_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CNT_W = 7,
  localparam int TAPS  = CNT_W + 1,
  localparam int SEL_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_src_sel,
  input  logic             sys_halt,
  input  logic             slow_tick,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             clr_strobe,
  output logic             timeout_pulse
);
  logic           count_tick;
  logic           step_in;
  logic           chain_step;
  logic           tap_rise;
  logic           hit;
  logic           restart;
  logic [CNT_W:0] ext_q;
  logic [CNT_W:0] ext_nxt;
  wdt_src_e       src;

  assign src = wdt_src_e'(cfg_src_sel);

  wdt_tick_gen #(.DIV_W(2)) tick_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (src),
    .halt       (sys_halt),
    .slow_tick  (slow_tick),
    .count_tick (count_tick)
  );

  assign step_in = count_tick & cfg_enable;

  wdt_count_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W)) chain_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (~cfg_enable),
    .restart  (restart),
    .step_in  (step_in),
    .ext_q    (ext_q),
    .ext_nxt  (ext_nxt),
    .ext_step (chain_step)
  );

  wdt_tap_mux #(.TAPS(TAPS), .SEL_W(SEL_W)) mux_i (
    .cur  (ext_q),
    .nxt  (ext_nxt),
    .sel  (tap_sel),
    .rise (tap_rise)
  );

  assign hit     = chain_step & tap_rise;
  assign restart = cfg_enable & (clr_strobe | hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timeout_pulse <= 1'b0;
    else        timeout_pulse <= cfg_enable & hit & ~clr_strobe;
  end
endmodule

// File: rtl/wdt_tap_timer_chk.sv
module wdt_tap_timer_chk #(
  parameter int CNT_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_enable,
  input logic           cfg_src_sel,
  input logic           sys_halt,
  input logic           clr_strobe,
  input logic           timeout_pulse,
  input logic           chain_step,
  input logic           restart,
  input logic [CNT_W:0] ext_q
);
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> (ext_q == '0));

  p_from_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> $past(chain_step));

  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_step && !restart && cfg_enable) |=> $stable(ext_q));

  p_clear_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe && cfg_enable) |=> (!timeout_pulse && ext_q == '0));

  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!timeout_pulse && ext_q == '0));

  p_halt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_halt && cfg_src_sel) |=> ($stable(ext_q) || ext_q == '0));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!timeout_pulse);
    end
  end
endmodule

bind wdt_tap_timer wdt_tap_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .cfg_src_sel   (cfg_src_sel),
  .sys_halt      (sys_halt),
  .clr_strobe    (clr_strobe),
  .timeout_pulse (timeout_pulse),
  .chain_step    (chain_step),
  .restart       (restart),
  .ext_q         (ext_q)
);

// File: tb/wdt_tap_timer_tb_top.sv
module wdt_tap_timer_tb_top;
  localparam int PRE_W = 2;
  localparam int CNT_W = 7;
  localparam int SEL_W = $clog2(CNT_W + 1);
  localparam int SLOW_PERIOD = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_enable = 1'b1;
  logic             cfg_src_sel = 1'b1;
  logic             sys_halt = 1'b0;
  logic             slow_tick = 1'b0;
  logic [SEL_W-1:0] tap_sel = '0;
  logic             clr_strobe = 1'b0;
  logic             timeout_pulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdt_tap_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_enable    (cfg_enable),
    .cfg_src_sel   (cfg_src_sel),
    .sys_halt      (sys_halt),
    .slow_tick     (slow_tick),
    .tap_sel       (tap_sel),
    .clr_strobe    (clr_strobe),
    .timeout_pulse (timeout_pulse)
  );

  // Low-speed oscillator model: one tick every SLOW_PERIOD clocks.
  initial begin
    forever begin
      repeat (SLOW_PERIOD - 1) @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(input int limit, output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!timeout_pulse && waited <= limit);
  endtask

  task automatic count_pulses(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (timeout_pulse) n++;
    end
  endtask

  // Measures the spacing of two consecutive time-outs (R2, R3, R4, R5).
  task automatic t_interval(input bit src, input int tap, input int exp, input string req);
    int w;
    cfg_src_sel = src;
    tap_sel = SEL_W'(tap);
    wait_pulse(6000, w);
    check(timeout_pulse, req, int'(timeout_pulse), 1);
    @(negedge clk);
    check(!timeout_pulse, "R5 pulse width", int'(timeout_pulse), 0);
    wait_pulse(6000, w);
    check(w + 1 == exp, req, w + 1, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!timeout_pulse, "R1 during reset", int'(timeout_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!timeout_pulse, "R1 after reset", int'(timeout_pulse), 0);
  endtask

  task automatic t_clear;
    int n;
    int w;
    cfg_src_sel = 1'b1;
    tap_sel = SEL_W'(2);
    n = 0;
    for (int k = 0; k < 8; k++) begin
      int m;
      clr_strobe = 1'b1;
      @(negedge clk);
      clr_strobe = 1'b0;
      count_pulses(40, m);
      n += m;
    end
    check(n == 0, "R6 clear keeps quiet", n, 0);
    clr_strobe = 1'b1;
    @(negedge clk);
    clr_strobe = 1'b0;
    wait_pulse(200, w);
    check(w >= 61 && w <= 64, "R6 full period after clear", w, 64);
  endtask

  task automatic t_disable;
    int n;
    int w;
    cfg_src_sel = 1'b1;
    tap_sel = '0;
    cfg_enable = 1'b0;
    n = 0;
    for (int k = 0; k < 5; k++) begin
      int m;
      clr_strobe = 1'b1;
      @(negedge clk);
      clr_strobe = 1'b0;
      count_pulses(60, m);
      n += m;
    end
    check(n == 0, "R7 no time-out while disabled", n, 0);
    cfg_enable = 1'b1;
    wait_pulse(200, w);
    check(w >= 13 && w <= 16, "R7 full period after enable", w, 16);
  endtask

  task automatic t_halt;
    int n;
    cfg_src_sel = 1'b1;
    tap_sel = '0;
    sys_halt = 1'b1;
    count_pulses(300, n);
    check(n == 0, "R8 divided source frozen", n, 0);
    t_interval(1'b0, 0, SLOW_PERIOD * 4, "R8 slow tick counts in halt");
    sys_halt = 1'b0;
  endtask

  initial begin
    t_reset();
    t_interval(1'b1, 0, 16, "R3 tap0 divided");
    t_interval(1'b1, 1, 32, "R4 tap1 divided");
    t_interval(1'b1, 3, 128, "R4 tap3 divided");
    t_interval(1'b1, 7, 2048, "R4 carry tap divided");
    t_interval(1'b0, 0, SLOW_PERIOD * 4, "R2 tap0 slow");
    t_interval(1'b0, 2, SLOW_PERIOD * 16, "R2 tap2 slow");
    t_clear();
    t_disable();
    t_halt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule